// File: doc/BRIEF.md
# Device-to-Host Frame Response Builder

This block assembles the two status frames a storage host port places in its receive area after a command finishes. The first is a 32-byte register frame. It carries a type code, the device status and error bytes, and a flag for a pending global interrupt, and it reflects command bytes 4 to 13 back to software. The second is an 8-byte set-device-bits frame. It carries the error byte, a masked status byte and a running word of completed queue tags.

Each frame leaves as a stream of byte writes. Every write carries an offset into the per-port receive area and one data byte. When the last byte has gone out, the block pulses the matching events toward the port's interrupt register logic.

A third request, the initial frame, sends a register frame after link-up or port reset. Its command image is built inside the block rather than taken from the command input. Requests are honoured only while the receive area is valid and frame reception is enabled.

Top module: `fis_resp_builder`

## Requirements
- R1: While `area_valid` or `rx_en` is low, requests are dropped. No byte is written, no event pulses, and the completed-tag word is not updated.
- R2: A register frame is written at offsets `RFIS_BASE`..`RFIS_BASE`+31 with these bytes: byte 0 = 0x34; byte 1 = 0x40 when `irq_pending` was high at acceptance, otherwise 0x00; byte 2 = status; byte 3 = error.
- R3: Register-frame bytes 4..13 equal bytes 4..13 of `cmd_frame` (byte k is bits 8k+7:8k). Bytes 14..31 are zero.
- R4: At the end of every register frame, `ev_d2h` pulses for one cycle. `ev_tfe` pulses in the same cycle only when status bit 0 was set.
- R5: A set-device-bits frame is written at offsets `SDB_BASE`..`SDB_BASE`+7. Byte 0 = error, byte 1 = 0, byte 2 = status AND 0x77, byte 3 = 0.
- R6: An accepted set-device-bits request ORs `done_tags` into the completed-tag word. The updated word goes out little-endian in bytes 4..7, and `ev_sdb` then pulses once.
- R7: An initial-frame request writes a register frame whose bytes 4..13 are all zero except byte 4 = 1 and byte 12 = 1. When `pkt_dev` is high, byte 5 = 0x14 and byte 6 = 0xEB.
- R8: Frame bytes are written one per clock in ascending offset order, starting the cycle after acceptance. The events pulse in the cycle after the last byte.
- R9: `busy` is high exactly while bytes are being written, and any request made while `busy` is high is dropped.
- R10: `tags_clear` empties the completed-tag word. If it coincides with an accepted set-device-bits request, the frame carries only the new `done_tags`.
- R11: When several requests arrive together, initial frame beats register frame, which beats set-device-bits. The losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| area_valid | input | 1 | Receive area is mapped and valid |
| rx_en | input | 1 | Frame reception enabled |
| reg_req | input | 1 | Build a register frame from `cmd_frame` |
| init_req | input | 1 | Build the initial register frame |
| sdb_req | input | 1 | Build a set-device-bits frame |
| pkt_dev | input | 1 | Port holds a packet-command device |
| dev_status | input | 8 | Device status byte |
| dev_error | input | 8 | Device error byte |
| cmd_frame | input | 128 | First 16 bytes of the last command frame |
| irq_pending | input | 1 | Some global interrupt is pending |
| done_tags | input | TAG_W | Newly completed queue tags |
| tags_clear | input | 1 | Empty the completed-tag word |
| busy | output | 1 | Frame write in progress |
| wr_valid | output | 1 | Byte write strobe |
| wr_offset | output | 8 | Byte offset in the receive area |
| wr_data | output | 8 | Byte to write |
| ev_tfe | output | 1 | Task-file-error event pulse |
| ev_d2h | output | 1 | Register-frame-received event pulse |
| ev_sdb | output | 1 | Set-device-bits event pulse |

## Verification
A corrupted byte counter shows up at the write port at once, as a skipped or repeated offset or a stream that runs past 32 or 8 bytes. It also moves the event pulse away from the cycle after the last byte. A wrong captured kind or flag shows up in the first header byte or in the event mix of that same frame. A wrong completed-tag word can stay hidden until the next set-device-bits frame, so the bench follows a run of such frames through accumulation, clearing and gated requests.

// File: rtl/fis_pkg.sv
package fis_pkg;
  typedef enum logic [1:0] {FK_REG = 2'd0, FK_INIT = 2'd1, FK_SDB = 2'd2} fis_kind_e;
  localparam logic [7:0] D2H_TYPE      = 8'h34;
  localparam logic [7:0] SDB_STAT_MASK = 8'h77;
  localparam logic [7:0] PKT_SIG_LO    = 8'h14;
  localparam logic [7:0] PKT_SIG_HI    = 8'hEB;
  localparam int         REG_LEN       = 32;
  localparam int         SDB_LEN       = 8;
  localparam int         ECHO_FIRST    = 4;
  localparam int         ECHO_BYTES    = 10;
endpackage

// File: rtl/fis_seq.sv
module fis_seq #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] last_idx,
  output logic             busy,
  output logic [IDX_W-1:0] idx,
  output logic             done
);
  logic             busy_d, done_d;
  logic [IDX_W-1:0] idx_d, lim_q, lim_d;

  always_comb begin
    busy_d = busy;
    idx_d  = idx;
    lim_d  = lim_q;
    done_d = 1'b0;
    if (!busy) begin
      if (start) begin
        busy_d = 1'b1;
        idx_d  = '0;
        lim_d  = last_idx;
      end
    end else if (idx == lim_q) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else begin
      idx_d = idx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      lim_q <= '0;
      done  <= 1'b0;
    end else begin
      busy  <= busy_d;
      idx   <= idx_d;
      lim_q <= lim_d;
      done  <= done_d;
    end
  end
endmodule

// File: rtl/fis_tag_accum.sv
module fis_tag_accum #(
  parameter int TAG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [TAG_W-1:0] tags,
  output logic [TAG_W-1:0] merged
);
  logic [TAG_W-1:0] acc_q;

  always_comb begin
    merged = (clr ? '0 : acc_q) | (add_en ? tags : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (clr || add_en) acc_q <= merged;
  end
endmodule

// File: rtl/fis_frame_mux.sv
module fis_frame_mux
  import fis_pkg::*;
(
  input  logic                 is_sdb,
  input  logic [4:0]           idx,
  input  logic [7:0]           status,
  input  logic [7:0]           error,
  input  logic                 irq_flag,
  input  logic [9:0][7:0]      echo,
  input  logic [31:0]          word,
  output logic [7:0]           data
);
  logic [3:0] eidx;
  always_comb eidx = 4'(idx - 5'd4);

  always_comb begin
    data = 8'h00;
    if (is_sdb) begin
      case (idx)
        5'd0: data = error;
        5'd2: data = status & SDB_STAT_MASK;
        5'd4, 5'd5, 5'd6, 5'd7: data = word[{idx[1:0], 3'b000} +: 8];
        default: data = 8'h00;
      endcase
    end else begin
      if (idx == 5'd0)      data = D2H_TYPE;
      else if (idx == 5'd1) data = {1'b0, irq_flag, 6'b0};
      else if (idx == 5'd2) data = status;
      else if (idx == 5'd3) data = error;
      else if (idx <= 5'd13) data = echo[eidx];
    end
  end
endmodule

// File: rtl/fis_resp_builder.sv
module fis_resp_builder
  import fis_pkg::*;
#(
  parameter int           TAG_W     = 32,
  parameter logic [7:0]   RFIS_BASE = 8'h40,
  parameter logic [7:0]   SDB_BASE  = 8'h58
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              area_valid,
  input  logic              rx_en,
  input  logic              reg_req,
  input  logic              init_req,
  input  logic              sdb_req,
  input  logic              pkt_dev,
  input  logic [7:0]        dev_status,
  input  logic [7:0]        dev_error,
  input  logic [127:0]      cmd_frame,
  input  logic              irq_pending,
  input  logic [TAG_W-1:0]  done_tags,
  input  logic              tags_clear,
  output logic              busy,
  output logic              wr_valid,
  output logic [7:0]        wr_offset,
  output logic [7:0]        wr_data,
  output logic              ev_tfe,
  output logic              ev_d2h,
  output logic              ev_sdb
);
  localparam int IDX_W = 5;

  logic             gate, any_req, accept, seq_done;
  logic [IDX_W-1:0] idx, last_idx;
  fis_kind_e        kind_sel, kind_q;
  logic [TAG_W-1:0] merged;
  logic [9:0][7:0]  echo_sel, echo_q;
  logic [7:0]       st_q, er_q;
  logic             irq_q, tfe_q;
  logic [31:0]      word_q;

  always_comb begin
    gate    = area_valid && rx_en;
    any_req = init_req || reg_req || sdb_req;
    accept  = gate && any_req && !busy;
    if (init_req)     kind_sel = FK_INIT;
    else if (reg_req) kind_sel = FK_REG;
    else              kind_sel = FK_SDB;
    last_idx = (kind_sel == FK_SDB) ? IDX_W'(SDB_LEN - 1) : IDX_W'(REG_LEN - 1);
  end

  for (genvar j = 0; j < ECHO_BYTES; j++) begin : g_echo
    always_comb begin
      if (kind_sel == FK_INIT) begin
        if (j == 0 || j == 8)        echo_sel[j] = 8'h01;
        else if (pkt_dev && j == 1)  echo_sel[j] = PKT_SIG_LO;
        else if (pkt_dev && j == 2)  echo_sel[j] = PKT_SIG_HI;
        else                         echo_sel[j] = 8'h00;
      end else begin
        echo_sel[j] = cmd_frame[8*(j+ECHO_FIRST) +: 8];
      end
    end
  end

  fis_seq #(.IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .last_idx(last_idx),
    .busy(busy), .idx(idx), .done(seq_done)
  );

  fis_tag_accum #(.TAG_W(TAG_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(tags_clear),
    .add_en(accept && kind_sel == FK_SDB), .tags(done_tags), .merged(merged)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= FK_REG;
      st_q   <= '0;
      er_q   <= '0;
      irq_q  <= 1'b0;
      tfe_q  <= 1'b0;
      echo_q <= '0;
      word_q <= '0;
    end else if (accept) begin
      kind_q <= kind_sel;
      st_q   <= dev_status;
      er_q   <= dev_error;
      irq_q  <= irq_pending;
      tfe_q  <= dev_status[0] && (kind_sel != FK_SDB);
      echo_q <= echo_sel;
      word_q <= 32'(merged);
    end
  end

  fis_frame_mux u_mux (
    .is_sdb(kind_q == FK_SDB), .idx(idx), .status(st_q), .error(er_q),
    .irq_flag(irq_q), .echo(echo_q), .word(word_q), .data(wr_data)
  );

  always_comb begin
    wr_valid  = busy;
    wr_offset = ((kind_q == FK_SDB) ? SDB_BASE : RFIS_BASE) + 8'(idx);
    ev_d2h    = seq_done && (kind_q != FK_SDB);
    ev_tfe    = seq_done && tfe_q;
    ev_sdb    = seq_done && (kind_q == FK_SDB);
  end
endmodule

// File: rtl/fis_resp_checker.sv
module fis_resp_checker #(
  parameter logic [7:0] RFIS_BASE = 8'h40,
  parameter logic [7:0] SDB_BASE  = 8'h58
) (
  input logic       clk,
  input logic       rst_n,
  input logic       area_valid,
  input logic       rx_en,
  input logic       busy,
  input logic       wr_valid,
  input logic [7:0] wr_offset,
  input logic [7:0] wr_data,
  input logic       ev_tfe,
  input logic       ev_d2h,
  input logic       ev_sdb
);
  AST_GATED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(area_valid && rx_en)) |=> !busy) else $error("gate"); // R1
  AST_REG_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_offset == RFIS_BASE) |-> wr_data == 8'h34) else $error("type"); // R2
  AST_TFE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tfe |-> ev_d2h) else $error("tfe"); // R4
  AST_SDB_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_offset == SDB_BASE + 8'd2) |-> (wr_data & 8'h88) == 8'h00) else $error("sdbst"); // R5
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(wr_valid)) |-> wr_offset == $past(wr_offset) + 8'd1) else $error("order"); // R8
  AST_EVT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_d2h || ev_sdb) |-> (!busy && $past(busy))) else $error("evt"); // R8
  AST_ONE_EVENT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_d2h && ev_sdb)) else $error("kind"); // R4
endmodule

bind fis_resp_builder fis_resp_checker #(.RFIS_BASE(RFIS_BASE), .SDB_BASE(SDB_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .area_valid(area_valid), .rx_en(rx_en), .busy(busy),
  .wr_valid(wr_valid), .wr_offset(wr_offset), .wr_data(wr_data),
  .ev_tfe(ev_tfe), .ev_d2h(ev_d2h), .ev_sdb(ev_sdb)
);

// File: tb/tb_fis_resp_builder.sv
`timescale 1ns/1ps
module tb_fis_resp_builder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic area_valid = 1'b1, rx_en = 1'b1, reg_req = 1'b0, init_req = 1'b0, sdb_req = 1'b0;
  logic pkt_dev = 1'b0, irq_pending = 1'b0, tags_clear = 1'b0;
  logic [7:0] dev_status = '0, dev_error = '0;
  logic [127:0] cmd_frame = '0;
  logic [31:0] done_tags = '0;
  logic busy, wr_valid, ev_tfe, ev_d2h, ev_sdb;
  logic [7:0] wr_offset, wr_data;

  fis_resp_builder dut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] cap [256];
  int nbytes, n_d2h, n_tfe, n_sdb, order_err, last_wr_cyc, ev_cyc;
  logic [7:0] prev_off;

  // status[31:24] error[23:16] irq[8] cmd seed[7:0]
  localparam logic [31:0] VEC [4] = '{32'h5000_0011, 32'h5104_01A0, 32'h4184_003C, 32'h00FF_01E7};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (wr_valid) begin
      if (nbytes > 0 && wr_offset != prev_off + 8'd1) order_err++;
      prev_off = wr_offset;
      cap[wr_offset] = wr_data;
      nbytes++;
      last_wr_cyc = cyc;
    end
    if (ev_d2h) begin n_d2h++; ev_cyc = cyc; end
    if (ev_tfe) n_tfe++;
    if (ev_sdb) begin n_sdb++; ev_cyc = cyc; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_cap();
    for (int i = 0; i < 256; i++) cap[i] = 8'h00;
    nbytes = 0; n_d2h = 0; n_tfe = 0; n_sdb = 0; order_err = 0;
    last_wr_cyc = -10; ev_cyc = -20;
  endtask

  task automatic set_cmd(input logic [7:0] seed);
    for (int k = 0; k < 16; k++) cmd_frame[8*k +: 8] = seed + 8'(k * 7);
  endtask

  // kind: 0 reg, 1 init, 2 sdb
  task automatic issue(input int kind);
    clr_cap();
    @(negedge clk);
    reg_req = (kind == 0); init_req = (kind == 1); sdb_req = (kind == 2);
    @(negedge clk);
    reg_req = 0; init_req = 0; sdb_req = 0;
    while (busy) @(negedge clk);
    #1;
  endtask

  function automatic logic [7:0] exp_reg(int k, logic [7:0] st, logic [7:0] er, logic irq);
    if (k == 0) return 8'h34;
    if (k == 1) return irq ? 8'h40 : 8'h00;
    if (k == 2) return st;
    if (k == 3) return er;
    if (k <= 13) return cmd_frame[8*k +: 8];
    return 8'h00;
  endfunction

  task automatic chk_sdb(input logic [7:0] st, input logic [7:0] er, input logic [31:0] w, input string req);
    logic [63:0] act, exp;
    for (int k = 0; k < 8; k++) act[8*k +: 8] = cap[8'h58 + k];
    exp = {w, 8'h00, st & 8'h77, 8'h00, er};
    chk(act == exp && nbytes == 8 && n_sdb == 1, req, act, exp);
  endtask

  initial begin
    clr_cap();
    repeat (3) @(negedge clk);
    // reset state
    chk(busy == 0 && wr_valid == 0 && !ev_d2h && !ev_sdb && !ev_tfe, "R9 reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4: table of register frames
    for (int v = 0; v < 4; v++) begin
      int bad;
      dev_status = VEC[v][31:24]; dev_error = VEC[v][23:16]; irq_pending = VEC[v][8];
      set_cmd(VEC[v][7:0]);
      issue(0);
      bad = 0;
      for (int k = 0; k < 32; k++)
        if (cap[8'h40 + k] != exp_reg(k, VEC[v][31:24], VEC[v][23:16], VEC[v][8])) bad++;
      chk(bad == 0, "R2 R3 frame bytes", bad, 0);
      chk(nbytes == 32 && order_err == 0, "R8 count/order", nbytes, 32);
      chk(n_d2h == 1 && n_tfe == int'(VEC[v][24]), "R4 events", n_tfe, VEC[v][24]);
      chk(ev_cyc == last_wr_cyc + 1, "R8 event timing", ev_cyc, last_wr_cyc + 1);
    end

    // R7 initial frame, plain device then packet device
    dev_status = 8'h50; dev_error = 8'h01; irq_pending = 0; set_cmd(8'hC3);
    for (int p = 0; p < 2; p++) begin
      logic [79:0] act, exp;
      pkt_dev = p[0];
      issue(1);
      for (int k = 0; k < 10; k++) act[8*k +: 8] = cap[8'h44 + k];
      exp = '0; exp[7:0] = 8'h01; exp[71:64] = 8'h01;
      if (p == 1) begin exp[15:8] = 8'h14; exp[23:16] = 8'hEB; end
      chk(act == exp && cap[8'h42] == 8'h50 && cap[8'h43] == 8'h01 && n_d2h == 1, "R7 init image", act, exp);
    end
    pkt_dev = 0;

    // R5 R6 set-device-bits accumulation
    dev_status = 8'hFF; dev_error = 8'h5A;
    done_tags = 32'h0000_0003; issue(2);
    chk_sdb(8'hFF, 8'h5A, 32'h0000_0003, "R5 R6 first sdb");
    chk(n_d2h == 0 && n_tfe == 0 && ev_cyc == last_wr_cyc + 1, "R6 sdb event only", n_d2h, 0);
    done_tags = 32'h8000_0100; issue(2);
    chk_sdb(8'hFF, 8'h5A, 32'h8000_0103, "R6 accumulate");

    // R10 clear
    @(negedge clk); tags_clear = 1; @(negedge clk); tags_clear = 0;
    done_tags = 32'h0000_0010; dev_status = 8'h08; issue(2);
    chk_sdb(8'h08, 8'h5A, 32'h0000_0010, "R10 clear");

    // R1 gating: rx_en low, then area invalid
    rx_en = 0; done_tags = 32'h0000_0004; issue(2);
    chk(nbytes == 0 && n_sdb == 0, "R1 rx_en off", nbytes, 0);
    rx_en = 1; area_valid = 0; issue(0);
    chk(nbytes == 0 && n_d2h == 0, "R1 area invalid", nbytes, 0);
    area_valid = 1; done_tags = 0; issue(2);
    chk_sdb(8'h08, 8'h5A, 32'h0000_0010, "R1 tags untouched");

    // R10 clear together with accepted request
    clr_cap();
    @(negedge clk); tags_clear = 1; sdb_req = 1; done_tags = 32'h0000_0200;
    @(negedge clk); tags_clear = 0; sdb_req = 0;
    while (busy) @(negedge clk);
    #1;
    chk_sdb(8'h08, 8'h5A, 32'h0000_0200, "R10 clear with add");

    // R11 priority: init + sdb together, then reg + sdb
    clr_cap();
    @(negedge clk); init_req = 1; sdb_req = 1; done_tags = 32'h0000_0001;
    @(negedge clk); init_req = 0; sdb_req = 0;
    while (busy) @(negedge clk);
    #1;
    chk(nbytes == 32 && n_d2h == 1 && n_sdb == 0 && cap[8'h44] == 8'h01, "R11 init wins", nbytes, 32);
    done_tags = 0; issue(2);
    chk_sdb(8'h08, 8'h5A, 32'h0000_0200, "R11 loser tags dropped");

    // R9 busy refusal
    dev_status = 8'h50; set_cmd(8'h21); clr_cap();
    @(negedge clk); reg_req = 1;
    @(negedge clk); reg_req = 0;
    chk(busy == 1, "R9 busy high", busy, 1);
    repeat (3) @(negedge clk);
    sdb_req = 1; init_req = 1; @(negedge clk); sdb_req = 0; init_req = 0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    #1;
    chk(nbytes == 32 && n_sdb == 0 && n_d2h == 1, "R9 refused during busy", nbytes, 32);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule